// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes (or 9-bit words) written by software into an asynchronous serial bit stream on a single line. Software writes a character into a holding register. The transmitter copies it into an internal shift register as soon as that register is free. While one character is shifting out, a second one can therefore wait in the holding register, and consecutive characters leave with no idle time between them.

Three registers sit behind one write port: data, control and baud. The control register enables the transmitter, picks 8-bit or 9-bit frames, supplies the ninth data bit, and can request a line break. The baud register selects a power-of-two divide of the system clock and an optional extra divide-by-39 prescale stage. The divided clock gives the oversampling tick, and each bit lasts 16 ticks. Two status outputs report whether the holding register is free and whether the transmitter has gone fully idle.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_done` is 1. The line stays at 1 whenever no frame is in progress.
- R2: An 8-bit frame (control bit 2 clear) is a 0 start bit, then data bits 0 to 7 with the least significant bit first, then a 1 stop bit.
- R3: With control bit 2 set, the frame carries 9 data bits. Bits 0 to 7 come from the data register and the ninth bit is control bit 3.
- R4: A write with `wr_sel`=0 stores `wr_val` and clears `hold_empty`. `hold_empty` returns to 1 once the character has moved into the shift register. A character written during a frame starts immediately after that frame's stop bit, with no idle bit in between.
- R5: `tx_done` is 1 only when no frame is in progress and no character is pending. It is 0 between back-to-back frames.
- R6: Control bit 0 enables the transmitter. While it is 0, no new frame starts and a pending character stays queued. Clearing it during a frame lets that frame finish intact.
- R7: While control bits 0 and 1 are both set, the line is held at 0 in whole frame times, each as long as a frame in the current mode. When bit 1 clears, the line sends exactly one 1 bit before the next start bit.
- R8: A write with `wr_sel`=2 sets the divide exponent `e` from `wr_val[2:0]`. The tick period is 2^e clocks and each bit lasts 16 ticks, so one bit lasts 16·2^e clocks.
- R9: Baud-register bit 7 adds a divide-by-39 stage ahead of the power-of-two divider, so one bit lasts 16·39·2^e clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register select: 0 data, 1 control, 2 baud |
| wr_val | input | 8 | Value written to the selected register |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Transmitter fully idle with nothing pending |

## Verification
The frame logic is exercised in several ways:
- Alternating-bit and asymmetric bytes expose bit-order and shift errors.
- 9-bit words with the ninth bit at 1 and at 0 separate the frame-length choice from the source of the extra bit.
- Two characters queued back to back show whether the hand-off from the holding register inserts idle time or loses a character.
- With the transmitter disabled, a pending character must stay queued. Disabling mid-frame must leave the frame intact.
- A break held across a frame boundary must last exactly two frame times and be followed by exactly one mark bit.
- Start-bit lengths measured with and without the divide-by-39 stage separate the power-of-two divider from the prescaler.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_BAUD = 2'd2,
        SEL_RSVD = 2'd3
    } sel_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_DATA,
        KIND_BREAK,
        KIND_MARK
    } kind_t;

    // field order sets the bit positions in the control register
    typedef struct packed {
        logic ninth;
        logic long_word;
        logic brk;
        logic tx_en;
    } ctrl_t;

    function automatic logic [IDX_W-1:0] frame_bits(input logic long_word, input kind_t k);
        if (k == KIND_MARK)
            return IDX_W'(1);
        return long_word ? IDX_W'(DATA_W + 3) : IDX_W'(DATA_W + 2);
    endfunction

    function automatic logic [FRAME_MAX-1:0] frame_image(input kind_t k, input logic long_word,
                                                         input logic ninth,
                                                         input logic [DATA_W-1:0] d);
        case (k)
            KIND_DATA:  return long_word ? {1'b1, ninth, d, 1'b0} : {2'b11, d, 1'b0};
            KIND_BREAK: return '0;
            default:    return '1;
        endcase
    endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int EXP_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [7:0]          wr_val,
    input  logic                load,
    output logic [DATA_W-1:0]   hold_data,
    output logic                pending,
    output ctrl_t               ctrl,
    output logic [EXP_W-1:0]    baud_exp,
    output logic                baud_pre,
    output logic                baud_wr
);

    logic wr_data;
    assign wr_data = wr_en && (wr_sel == SEL_DATA);
    assign baud_wr = wr_en && (wr_sel == SEL_BAUD);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            pending   <= 1'b0;
            ctrl      <= '0;
            baud_exp  <= '0;
            baud_pre  <= 1'b0;
        end else begin
            if (load)
                pending <= 1'b0;
            if (wr_data) begin
                hold_data <= wr_val[DATA_W-1:0];
                pending   <= 1'b1;
            end
            if (wr_en && (wr_sel == SEL_CTRL))
                ctrl <= ctrl_t'(wr_val[3:0]);
            if (baud_wr) begin
                baud_exp <= wr_val[EXP_W-1:0];
                baud_pre <= wr_val[7];
            end
        end
    end

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int EXP_W   = 3,
    parameter int PRE_DIV = 39
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int DIV_W = (2 ** EXP_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_hit;
    logic [DIV_W:0]   div_lim;

    assign pre_hit = !pre_en || (pre_cnt == PRE_W'(PRE_DIV - 1));
    assign div_lim = ((DIV_W + 1)'(1) << exp_sel) - (DIV_W + 1)'(1);
    assign tick    = pre_hit && ({1'b0, div_cnt} == div_lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_hit ? '0 : pre_cnt + PRE_W'(1);
            if (pre_hit)
                div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        end
    end

    // R9: with the prescaler on, two prescale outputs never come on adjacent cycles
    a_r9_prescale_gap: assert property (@(posedge clk) disable iff (rst)
        (pre_en && pre_hit) |=> (!pre_en || !pre_hit));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ctrl_t             ctrl,
    input  logic              pending,
    input  logic [DATA_W-1:0] hold_data,
    output logic              load,
    output logic              busy,
    output logic              txd_bit
);

    localparam int SUB_W = $clog2(OVERSAMPLE);

    kind_t                kind_q;
    kind_t                next_kind;
    logic [FRAME_MAX-1:0] shreg;
    logic [IDX_W-1:0]     bit_idx;
    logic [IDX_W-1:0]     len_q;
    logic [SUB_W-1:0]     sub;
    logic                 bit_end;
    logic                 frame_end;
    logic                 decide;

    assign busy      = (kind_q != KIND_NONE);
    assign bit_end   = busy && tick && (sub == SUB_W'(OVERSAMPLE - 1));
    assign frame_end = bit_end && (bit_idx == len_q - IDX_W'(1));
    assign decide    = !busy || frame_end;
    assign txd_bit   = busy ? shreg[0] : 1'b1;

    always_comb begin
        if (frame_end && (kind_q == KIND_BREAK) && !ctrl.brk)
            next_kind = KIND_MARK;
        else if (ctrl.tx_en && ctrl.brk)
            next_kind = KIND_BREAK;
        else if (ctrl.tx_en && pending)
            next_kind = KIND_DATA;
        else
            next_kind = KIND_NONE;
    end

    assign load = decide && (next_kind == KIND_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= KIND_NONE;
            shreg   <= '1;
            bit_idx <= '0;
            len_q   <= '0;
            sub     <= '0;
        end else if (decide) begin
            kind_q  <= next_kind;
            shreg   <= frame_image(next_kind, ctrl.long_word, ctrl.ninth, hold_data);
            len_q   <= frame_bits(ctrl.long_word, next_kind);
            bit_idx <= '0;
            sub     <= '0;
        end else if (busy && tick) begin
            if (bit_end) begin
                sub     <= '0;
                shreg   <= {1'b1, shreg[FRAME_MAX-1:1]};
                bit_idx <= bit_idx + IDX_W'(1);
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

    // R2: a data frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd_bit);

    // R7: the end of a break with the request withdrawn is followed by a mark bit
    a_r7_mark_follows: assert property (@(posedge clk) disable iff (rst)
        (frame_end && kind_q == KIND_BREAK && !ctrl.brk) |=> (kind_q == KIND_MARK && txd_bit));

    // R8: the shifted bits only move on a tick
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(shreg));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int EXP_W      = 3,
    parameter int PRE_DIV    = 39,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_val,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_done
);

    logic [DATA_W-1:0] hold_data;
    logic              pending;
    ctrl_t             ctrl;
    logic [EXP_W-1:0]  baud_exp;
    logic              baud_pre;
    logic              baud_wr;
    logic              load;
    logic              busy;
    logic              tick;
    logic              txd_bit;

    sertx_regs #(.EXP_W(EXP_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val),
        .load      (load),
        .hold_data (hold_data),
        .pending   (pending),
        .ctrl      (ctrl),
        .baud_exp  (baud_exp),
        .baud_pre  (baud_pre),
        .baud_wr   (baud_wr)
    );

    sertx_baud #(.EXP_W(EXP_W), .PRE_DIV(PRE_DIV)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .clr     (baud_wr || !busy),
        .pre_en  (baud_pre),
        .exp_sel (baud_exp),
        .tick    (tick)
    );

    sertx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctrl      (ctrl),
        .pending   (pending),
        .hold_data (hold_data),
        .load      (load),
        .busy      (busy),
        .txd_bit   (txd_bit)
    );

    assign txd        = txd_bit;
    assign hold_empty = !pending;
    assign tx_done    = !busy && !pending;

    // R5: a fully idle transmitter leaves the line high
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> txd);

    // R4: moving a character out of the holding register frees it
    a_r4_load_empties: assert property (@(posedge clk) disable iff (rst)
        (load && !(wr_en && wr_sel == SEL_DATA)) |=> hold_empty);

    // R6: a frame only starts while enabled
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl.tx_en));

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_val = 8'd0;
    wire        txd;
    wire        hold_empty;
    wire        tx_done;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sertx_top i_sertx_top (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_val     (wr_val),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_done    (tx_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_val = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fall(output bit found);
        int t = 0;
        found = 1'b1;
        while (txd !== 1'b0) begin
            @(negedge clk);
            t++;
            if (t > 20000) begin
                found = 1'b0;
                break;
            end
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (tx_done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // samples each bit in its middle, 16 clocks per bit (exponent 0, no prescale)
    task automatic recv(input int nbits, output int val, output bit frame_ok);
        bit found;
        val = 0;
        wait_fall(found);
        repeat (8) @(negedge clk);
        frame_ok = found && (txd === 1'b0);
        for (int i = 0; i < nbits; i++) begin
            repeat (16) @(negedge clk);
            if (txd === 1'b1) val |= (1 << i);
        end
        repeat (16) @(negedge clk);
        frame_ok = frame_ok && (txd === 1'b1);
    endtask

    task automatic count_low(output int n);
        bit found;
        n = 0;
        wait_fall(found);
        while (found && txd === 1'b0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(txd === 1'b1, "R1 reset txd", int'(txd), 1);
        check(hold_empty === 1'b1, "R1 reset hold_empty", int'(hold_empty), 1);
        check(tx_done === 1'b1, "R1 reset tx_done", int'(tx_done), 1);
    endtask

    task automatic t_byte(input logic [7:0] d);
        int v; bit ok;
        wr(2'd0, d);
        recv(8, v, ok);
        check(v == int'(d), "R2 byte value", v, int'(d));
        check(ok, "R2 start/stop levels", int'(ok), 1);
        wait_done();
        check(tx_done === 1'b1 && txd === 1'b1, "R1 idle after frame", int'(txd), 1);
    endtask

    task automatic t_nine(input bit nb, input logic [7:0] d);
        int v; bit ok;
        int exp9 = int'({nb, d});
        wr(2'd1, {4'd0, nb, 1'b1, 1'b0, 1'b1});
        wr(2'd0, d);
        recv(9, v, ok);
        check(v == exp9, "R3 nine-bit value", v, exp9);
        check(ok, "R3 nine-bit framing", int'(ok), 1);
        wait_done();
        wr(2'd1, 8'h01);
    endtask

    task automatic t_double();
        int va, vb, gap; bit oka, okb;
        fork
            begin
                recv(8, va, oka);
                check(tx_done === 1'b0, "R5 tx_done low between frames", int'(tx_done), 0);
                gap = 0;
                while (txd === 1'b1 && gap < 100) begin
                    @(negedge clk);
                    gap++;
                end
                recv(8, vb, okb);
            end
            begin
                wr(2'd0, 8'hC3);
                repeat (3) @(negedge clk);
                check(hold_empty === 1'b1, "R4 hold_empty after move", int'(hold_empty), 1);
                wr(2'd0, 8'h5A);
                check(hold_empty === 1'b0, "R4 hold_empty after write", int'(hold_empty), 0);
                check(tx_done === 1'b0, "R5 tx_done while busy", int'(tx_done), 0);
            end
        join
        check(va == 32'hC3 && oka, "R4 first queued char", va, 32'hC3);
        check(vb == 32'h5A && okb, "R4 second queued char", vb, 32'h5A);
        check(gap == 8, "R4 no idle between frames", gap, 8);
        wait_done();
    endtask

    task automatic t_enable();
        int highs = 0; int v; bit ok;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h42);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        check(highs == 200, "R6 line idle while disabled", highs, 200);
        check(hold_empty === 1'b0, "R6 char stays queued", int'(hold_empty), 0);
        wr(2'd1, 8'h01);
        recv(8, v, ok);
        check(v == 32'h42 && ok, "R6 queued char sent on enable", v, 32'h42);
        wait_done();
        fork
            recv(8, v, ok);
            begin
                wr(2'd0, 8'h81);
                repeat (40) @(negedge clk);
                wr(2'd1, 8'h00);
            end
        join
        check(v == 32'h81 && ok, "R6 frame finishes after disable", v, 32'h81);
        wait_done();
        check(tx_done === 1'b1 && txd === 1'b1, "R6 idle after disabled frame", int'(txd), 1);
        wr(2'd1, 8'h01);
    endtask

    task automatic t_break();
        int low = 0; int high = 0; bit found;
        wr(2'd1, 8'h03);
        fork
            begin
                wait_fall(found);
                while (found && txd === 1'b0 && low < 5000) begin
                    low++;
                    @(negedge clk);
                end
                while (txd === 1'b1 && high < 5000) begin
                    high++;
                    @(negedge clk);
                end
            end
            begin
                repeat (250) @(negedge clk);
                wr(2'd1, 8'h01);
                wr(2'd0, 8'h55);
            end
        join
        check(low == 320, "R7 break of two whole frames", low, 320);
        check(high == 16, "R7 one mark bit after break", high, 16);
        wait_done();
    endtask

    task automatic t_baud();
        int n;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h01);
        count_low(n);
        check(n == 64, "R8 start bit at exponent 2", n, 64);
        wait_done();
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h01);
        count_low(n);
        check(n == 624, "R9 start bit with prescale", n, 624);
        wait_done();
        wr(2'd2, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        wr(2'd1, 8'h01);
        t_byte(8'hA5);
        t_byte(8'h01);
        t_nine(1'b1, 8'h3C);
        t_nine(1'b0, 8'hFF);
        t_double();
        t_enable();
        t_break();
        t_baud();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule